// File: doc/BRIEF.md
# Wrapping Double-to-Int32 Conversion Unit

This unit turns a 64-bit IEEE 754 double-precision operand into a 32-bit signed integer. It always truncates toward zero. When the value does not fit in 32 bits, the unit does not clamp it. It keeps the low 32 bits of the exact truncated integer, so the result wraps around modulo 2^32. That 32-bit value is then sign-extended to the integer register width. Infinities and NaNs produce zero.

Each request carries a 32-bit instruction word alongside the operand. The unit checks the fixed fields of that word against the one encoding it implements. If the word matches, the converted value and the exception flags appear on the output one clock later. If it does not match, the unit raises an illegal-instruction strobe instead of a result.

Top module: `f2i_wrap_unit`

## Requirements
- R1: A request (in_valid high) is accepted only when in_insn[31:25]=1100001, in_insn[24:20]=01000, in_insn[14:12]=001 and in_insn[6:0]=1010011; bits 19:15 and 11:7 are don't-care.
- R2: out_valid and out_illegal rise exactly one clock after the request that caused them. They are low in every cycle that follows an idle input, and low after reset, where out_result and out_flags are zero.
- R3: For an accepted finite operand, out_result[31:0] equals bits 31:0 of the exact two's complement integer obtained by truncating toward zero. No bound is applied.
- R4: out_result is out_result[31] sign-extended across the full XLEN width (XLEN is 32 or 64).
- R5: +infinity, -infinity and every NaN, quiet or signalling, give a result of zero with flags 10000.
- R6: The invalid flag, out_flags[4], is set for any finite operand whose truncated value lies outside [-2^31, 2^31-1]. For example, -2^31 is valid and -2^31-1 is invalid.
- R7: The inexact flag, out_flags[0], is set only when invalid is clear and nonzero fraction bits were discarded. out_flags[3:1] are always zero.
- R8: A finite operand with an unbiased exponent of 84 or more gives a result of zero, with invalid set.
- R9: Subnormals and all values with magnitude below 1.0 give zero, with inexact set when the value is nonzero. Negative zero gives zero with no flags.
- R10: A request whose instruction word does not match raises out_illegal in place of out_valid, with out_result and out_flags zero.
- R11: Rounding is always toward zero, whatever the sign; for example, -2.7 gives -2 and 3.99 gives 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_insn | input | 32 | Instruction word to decode |
| in_operand | input | 64 | Double-precision operand |
| out_valid | output | 1 | Converted result is present |
| out_illegal | output | 1 | Request carried an unsupported encoding |
| out_result | output | XLEN | Sign-extended wrapped integer |
| out_flags | output | 5 | Exception flags: bit 4 invalid, bit 0 inexact |

## Verification
Two things can happen to the same operand in the same cycle. It can wrap, losing its upper integer bits, and also be flagged invalid. A negative value near -2^31 can also lose fraction bits while its truncated magnitude still fits. The bench provokes both with operands such as 2^32+5, -2^31-1, -2^31-0.5, 1e20 and the largest finite value. It compares the result and the flags together against a real-number truncation model, checking that the wrapped bits are kept, that invalid is raised only when the value falls out of range, and that inexact stays clear whenever invalid is set.

// File: rtl/f2i_wrap_pkg.sv
package f2i_wrap_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int INT_W   = 32;
  localparam int BIAS    = 1023;
  localparam int FLAG_W  = 5;
  localparam int FLG_NV  = 4;
  localparam int FLG_NX  = 0;
  // exponent beyond which the lowest mantissa bit sits at or above 2^INT_W
  localparam int WRAP_ZERO_EXP = INT_W + FRAC_W;

  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

  // fixed fields of the one supported instruction word
  localparam logic [31:0] ENC_MASK  = {7'h7F, 5'h1F, 5'h00, 3'h7, 5'h00, 7'h7F};
  localparam logic [31:0] ENC_VALUE = {7'b1100001, 5'b01000, 5'h00, 3'b001, 5'h00, 7'b1010011};

  function automatic logic [EXP_W-1:0] fexp(input logic [63:0] op);
    return op[62:52];
  endfunction

  function automatic logic signed [12:0] unbiased(input logic [63:0] op);
    return $signed({2'b00, op[62:52]}) - 13'sd1023;
  endfunction

  // low INT_W bits of the truncated magnitude
  function automatic logic [INT_W-1:0] mag_low(input logic [63:0] op);
    logic [MANT_W-1:0]  m;
    logic [MANT_W-1:0]  r;
    logic [63:0]        w;
    logic signed [12:0] u;
    logic [5:0]         sh;
    m = {1'b1, op[51:0]};
    u = unbiased(op);
    if (fexp(op) == '0 || fexp(op) == EXP_ALL1 || u < 0) return '0;
    if (u <= 13'sd52) begin
      sh = 6'(13'sd52 - u);
      r  = m >> sh;
      return r[INT_W-1:0];
    end
    if (u < 13'sd84) begin
      sh = 6'(u - 13'sd52);
      w  = {11'b0, m} << sh;
      return w[INT_W-1:0];
    end
    return '0;
  endfunction

  // nonzero fraction bits dropped by truncation
  function automatic logic frac_lost(input logic [63:0] op);
    logic [MANT_W-1:0]  m;
    logic [MANT_W-1:0]  mask;
    logic signed [12:0] u;
    logic [5:0]         sh;
    m = {1'b1, op[51:0]};
    u = unbiased(op);
    if (fexp(op) == '0)      return op[51:0] != '0;
    if (fexp(op) == EXP_ALL1) return 1'b0;
    if (u < 0)               return 1'b1;
    if (u >= 13'sd52)        return 1'b0;
    sh   = 6'(13'sd52 - u);
    mask = (53'd1 << sh) - 53'd1;
    return (m & mask) != '0;
  endfunction

  // truncated value outside the signed 32-bit range
  function automatic logic out_of_range(input logic [63:0] op);
    logic signed [12:0] u;
    u = unbiased(op);
    if (fexp(op) == EXP_ALL1) return 1'b1;
    if (fexp(op) == '0)      return 1'b0;
    if (u >= 13'sd32)        return 1'b1;
    if (u == 13'sd31)        return !op[63] || (op[51:21] != '0);
    return 1'b0;
  endfunction
endpackage

// File: rtl/f2i_insn_match.sv
module f2i_insn_match
  import f2i_wrap_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit
);
  assign hit = (insn & ENC_MASK) == ENC_VALUE;
endmodule

// File: rtl/f2i_trunc_core.sv
module f2i_trunc_core
  import f2i_wrap_pkg::*;
(
  input  logic [63:0]      op,
  output logic [INT_W-1:0] val32,
  output logic             nv,
  output logic             nx,
  output logic             w_special,
  output logic             w_huge,
  output logic             w_tiny,
  output logic             w_oor
);
  logic [INT_W-1:0] mag;
  logic             lost;

  assign mag       = mag_low(op);
  assign lost      = frac_lost(op);
  assign w_special = fexp(op) == EXP_ALL1;
  assign w_oor     = out_of_range(op);
  assign w_huge    = !w_special && (unbiased(op) >= 13'(WRAP_ZERO_EXP));
  assign w_tiny    = fexp(op) < EXP_W'(BIAS);

  assign val32 = w_special ? '0 : (op[63] ? (~mag + 1'b1) : mag);
  assign nv    = w_special | w_oor;
  assign nx    = !nv && lost;
endmodule

// File: rtl/f2i_wrap_unit.sv
module f2i_wrap_unit
  import f2i_wrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [63:0]     in_operand,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [XLEN-1:0] out_result,
  output logic [4:0]      out_flags
);
  logic             dec_hit;
  logic             w_accept;
  logic             w_reject;
  logic [INT_W-1:0] val32;
  logic             nv;
  logic             nx;
  logic             w_special;
  logic             w_huge;
  logic             w_tiny;
  logic             w_oor;
  logic [XLEN-1:0]  wide;
  logic [FLAG_W-1:0] flag_vec;

  f2i_insn_match u_match (.insn(in_insn), .hit(dec_hit));

  f2i_trunc_core u_core (
    .op(in_operand), .val32(val32), .nv(nv), .nx(nx),
    .w_special(w_special), .w_huge(w_huge), .w_tiny(w_tiny), .w_oor(w_oor)
  );

  assign w_accept = in_valid && dec_hit;
  assign w_reject = in_valid && !dec_hit;

  generate
    if (XLEN > INT_W) begin : g_sext
      assign wide = {{(XLEN-INT_W){val32[INT_W-1]}}, val32};
    end else begin : g_narrow
      assign wide = val32;
    end
  endgenerate

  always_comb begin
    flag_vec         = '0;
    flag_vec[FLG_NV] = nv;
    flag_vec[FLG_NX] = nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_flags   <= '0;
    end else begin
      out_valid   <= w_accept;
      out_illegal <= w_reject;
      out_result  <= w_accept ? wide : '0;
      out_flags   <= w_accept ? flag_vec : '0;
    end
  end

  // R2: a strobe only follows a request
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_illegal) |-> $past(in_valid));

  // R10: a rejected word yields no data and no flags
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_valid && out_result == '0 && out_flags == '0));

  // R5: specials give zero with only invalid
  p_special_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_accept && w_special) |=> (out_result == '0 && out_flags == 5'b10000));

  // R6: out-of-range finite input raises invalid
  p_range_nv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_accept && w_oor) |=> out_flags[FLG_NV]);

  // R7: unused flags stay clear and inexact never joins invalid
  p_flag_mix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3:1] == '0 && !(out_flags[FLG_NV] && out_flags[FLG_NX])));

  // R8: large exponents leave no low bits
  p_huge_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_accept && w_huge) |=> (out_result == '0));

  // R9: magnitudes below one give zero without invalid
  p_tiny_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_accept && w_tiny) |=> (out_result == '0 && !out_flags[FLG_NV]));

  generate
    if (XLEN > INT_W) begin : g_sext_chk
      // R4: upper bits copy bit 31
      p_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[XLEN-1:INT_W] == {(XLEN-INT_W){out_result[INT_W-1]}}));
    end
  endgenerate
endmodule

// File: tb/tb_f2i_wrap_unit.sv
`timescale 1ns/1ps
module tb_f2i_wrap_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     in_insn = '0;
  logic [63:0]     in_operand = '0;
  logic            out_valid;
  logic            out_illegal;
  logic [XLEN-1:0] out_result;
  logic [4:0]      out_flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit          v;
    bit          ill;
    logic [63:0] res;
    logic [4:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  f2i_wrap_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_operand(in_operand), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_result(out_result), .out_flags(out_flags)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic longint floor_ll(real x);
    longint li;
    li = longint'(x);
    if (real'(li) > x) li = li - 1;
    return li;
  endfunction

  function automatic logic [31:0] mk_insn(logic [4:0] rs1, logic [4:0] rd);
    return {7'b1100001, 5'b01000, rs1, 3'b001, rd, 7'b1010011};
  endfunction

  function automatic exp_t ref_model(bit v, logic [31:0] ins, logic [63:0] op, string tag);
    exp_t e;
    real r, m, qt, rem, frac;
    longint fq, lowl;
    logic [31:0] low, val;
    bit inv, nx;
    e.v = 0; e.ill = 0; e.res = '0; e.fl = '0; e.tag = tag;
    if (!v) return e;
    if (!(ins[31:25] == 7'b1100001 && ins[24:20] == 5'b01000 &&
          ins[14:12] == 3'b001 && ins[6:0] == 7'b1010011)) begin
      e.ill = 1;
      return e;
    end
    e.v = 1;
    if (op[62:52] == 11'h7FF) begin
      e.fl = 5'b10000;
      return e;
    end
    r = $bitstoreal(op);
    m = op[63] ? -r : r;
    inv = op[63] ? (m >= 2147483649.0) : (m >= 2147483648.0);
    if (m >= 2.0**84) low = '0;
    else begin
      qt   = m / 4294967296.0;
      fq   = floor_ll(qt);
      rem  = m - real'(fq) * 4294967296.0;
      lowl = floor_ll(rem);
      low  = lowl[31:0];
    end
    frac = (m < 2.0**53) ? (m - real'(floor_ll(m))) : 0.0;
    nx   = !inv && (frac != 0.0);
    val  = op[63] ? (32'd0 - low) : low;
    e.res = {{32{val[31]}}, val};
    e.fl  = {inv, 3'b000, nx};
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    if (e.v)        check("R1", "out_valid", 64'(out_valid), 64'(1));
    else if (e.ill) check("R10", "out_illegal", 64'(out_illegal), 64'(1));
    else            check("R2", "idle strobes", 64'({out_valid, out_illegal}), 64'(0));
    if (e.v) check("R2", "out_illegal low on accept", 64'(out_illegal), 64'(0));
    if (e.ill) check("R10", "out_valid low on reject", 64'(out_valid), 64'(0));
    check(e.tag, "out_result", out_result, e.res);
    check(e.ill ? "R10" : "R7", "out_flags", 64'(out_flags), 64'(e.fl));
    if (e.v) check("R4", "upper half", 64'(out_result[63:32]), 64'({32{out_result[31]}}));
  endtask

  task automatic cycle(bit v, logic [31:0] ins, logic [63:0] op, string tag);
    @(negedge clk);
    compare_front();
    in_valid   = v;
    in_insn    = ins;
    in_operand = op;
    q.push_back(ref_model(v, ins, op, tag));
  endtask

  task automatic conv(real x, string tag);
    cycle(1, mk_insn(5'($urandom), 5'($urandom)), $realtobits(x), tag);
  endtask

  task automatic convb(logic [63:0] b, string tag);
    cycle(1, mk_insn(5'($urandom), 5'($urandom)), b, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset valid", 64'(out_valid), 64'(0));
    check("R2", "reset illegal", 64'(out_illegal), 64'(0));
    check("R2", "reset result", out_result, 64'(0));
    check("R2", "reset flags", 64'(out_flags), 64'(0));

    // R3 in-range and R11 truncation direction
    conv(1.0, "R3");
    conv(-2.7, "R11");
    conv(3.99, "R11");
    conv(-7.5, "R11");
    conv(2147483647.0, "R3");
    conv(-2147483648.0, "R6");
    conv(-2147483648.5, "R6");
    // R6 wrapping out of range
    conv(2147483648.0, "R6");
    conv(-2147483649.0, "R6");
    conv(4294967301.0, "R3");
    conv(-4294967301.0, "R3");
    conv(1.0e20, "R3");
    conv(2.0**83 + 2.0**52 + 2.0**40, "R3");
    // R8 large exponents
    conv(2.0**84, "R8");
    convb(64'h7FEF_FFFF_FFFF_FFFF, "R8");
    convb(64'hFFEF_FFFF_FFFF_FFFF, "R8");
    // R9 small magnitudes
    convb(64'h0000_0000_0000_0001, "R9");
    conv(0.5, "R9");
    conv(-0.5, "R9");
    convb(64'h8000_0000_0000_0000, "R9");
    convb(64'h0000_0000_0000_0000, "R9");
    // R5 specials
    convb(64'h7FF0_0000_0000_0000, "R5");
    convb(64'hFFF0_0000_0000_0000, "R5");
    convb(64'h7FF8_0000_0000_0000, "R5");
    convb(64'h7FF0_0000_0000_0001, "R5");
    convb(64'hFFFF_FFFF_FFFF_FFFF, "R5");
    // R10 near-miss encodings, interleaved with accepted ones
    cycle(1, mk_insn(5'd3, 5'd4) & ~32'h0000_7000, $realtobits(5.0), "R10");
    conv(6.0, "R3");
    cycle(1, mk_insn(5'd3, 5'd4) | 32'h0000_7000, $realtobits(5.0), "R10");
    cycle(1, mk_insn(5'd3, 5'd4) ^ 32'h0080_0000, $realtobits(5.0), "R10");
    cycle(1, mk_insn(5'd3, 5'd4) ^ 32'h0200_0000, $realtobits(5.0), "R10");
    cycle(1, mk_insn(5'd3, 5'd4) ^ 32'h0000_0001, $realtobits(5.0), "R10");
    cycle(1, mk_insn(5'd3, 5'd4) ^ 32'h0000_2000, $realtobits(5.0), "R10");
    // R2 idle gaps
    cycle(0, mk_insn(5'd0, 5'd0), $realtobits(9.0), "R2");
    cycle(0, '0, '0, "R2");
    conv(-123456.75, "R11");
    cycle(0, mk_insn(5'd1, 5'd1), '0, "R2");

    // random operands near the integer range
    for (int i = 0; i < 300; i++) begin
      logic [10:0] ex;
      ex = 11'(1018 + ($urandom % 72));
      convb({1'($urandom), ex, 20'($urandom), 32'($urandom)}, "R3");
      if (($urandom % 7) == 0) cycle(0, '0, '0, "R2");
    end
    // fully random operands
    for (int i = 0; i < 60; i++) convb({32'($urandom), 32'($urandom)}, "R3");
    // random instruction words
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w;
      w = (($urandom % 2) == 0) ? 32'($urandom) : (mk_insn(5'($urandom), 5'($urandom)) ^ (32'd1 << ($urandom % 32)));
      cycle(1, w, $realtobits(-3.25), "R1");
    end

    cycle(0, '0, '0, "R2");
    cycle(0, '0, '0, "R2");
    done = 1;
    summary();
    $finish;
  end
endmodule